// File: doc/BRIEF.md
# Polled-Flag Serial Transmitter

This block sends asynchronous serial frames on a single line. The bit period is a programmable count of timer ticks, where a timer tick is a one-cycle enable on `tmr_tick`. The host and the block share one 16-bit transmit register. The host loads a word with the top bit clear. The block uses a set top bit to mean "register empty", so a clear top bit marks new data waiting to be sent.

While the line is idle, the block looks at the register once per bit period. When it finds data, it does four things in the same cycle:
- copies the low 15 bits into its shift register,
- sets the top bit of the shared register again,
- pulses `irq`,
- drives the start bit low.

The frame then carries the programmed number of data bits, least significant first. An optional parity bit follows, derived from a running count of transmitted ones. The frame ends with a single high stop bit, and the block then goes back to polling.

A pulse on `init` re-initialises the block as a transmitter. It forces the line high, restarts the bit timer, abandons any frame in flight and pulses `irq`. Software uses that first interrupt to load the first word.

Top module: `uart_flag_tx`

## Requirements
- R1: Every transmitted bit lasts exactly `baud_period` timer ticks. A value of 0 behaves as 1. The line changes only in a cycle with `tmr_tick` high, or on `init`.
- R2: A host write (`host_wr`) replaces the whole shared register. A word written with bit 15 = 1 counts as "empty" and is never transmitted: the line stays high.
- R3: While idle, the empty flag is examined once per bit period. A word written with bit 15 = 0 starts its frame no more than one bit period (plus two clock cycles) later.
- R4: When the block takes a word, three things happen in the same cycle. The line goes low for the start bit. `irq` is high for one cycle. The shared register reads back as the written word with bit 15 = 1.
- R5: Data bits leave least significant bit first, one per bit period. The count comes from `word_len`: values 1 to 14 are used as given, 0 acts as 1, and 15 acts as 14. Data bits above that count are not sent.
- R6: The parity bit is taken from the count of 1 data bits in the current frame. Even parity sends the count's LSB. Odd parity sends its complement. The count restarts at zero for every frame.
- R7: `par_mode` selects the parity: 00 or 01 means no parity slot, 10 means even, and 11 means odd.
- R8: Each frame ends with one high stop bit lasting exactly one bit period. If another word is already waiting, its start bit follows immediately, so start edges are spaced (frame bits × bit period) apart.
- R9: `init` drives the line high, pulses `irq` for one cycle, restarts the bit timer and drops any frame in progress.
- R10: After reset (synchronous, active high) the line is high, `irq` is low and the shared register reads 0x8000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_tick | input | 1 | Timer-clock enable, one tick per cycle it is high |
| init | input | 1 | Re-initialise as transmitter (one-cycle pulse) |
| baud_period | input | 16 | Bit period in timer ticks |
| word_len | input | 4 | Data bits per frame, clamped to 1..14 |
| par_mode | input | 2 | Parity select: 0x none, 10 even, 11 odd |
| host_wr | input | 1 | Host write strobe for the shared register |
| host_wdata | input | 16 | Host write data; bit 15 must be 0 for new data |
| data_reg | output | 16 | Shared register contents, bit 15 = empty flag |
| txd | output | 1 | Serial line, idle high |
| irq | output | 1 | One-cycle interrupt on init and on each take |

## Verification
The hardest case to reach from the ports is two frames back to back. For the stop bit to be followed at once by the next start bit, the host must refill the register after the take but before the stop bit ends. The bench does this by writing the second word straight after it observes the first start edge, and then measuring the distance between the two falling edges.

Other directed cases drive the block into specific states:
- an `init` pulse in the middle of a frame,
- a write with the flag already set,
- word lengths of 0 and 15,
- timer ticks on only every other cycle.

Random frames cover data values, lengths, parity modes and bit periods.

// File: rtl/uart_ftx_pkg.sv
package uart_ftx_pkg;

    localparam int MAX_LEN = 14;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_DATA = 2'd1,
        TX_PAR  = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic load;
        logic shift;
    } sh_ctl_t;

    // clamp a requested word length into the supported range 1..MAX_LEN
    function automatic logic [3:0] clamp_len(input logic [3:0] req);
        if (req == 4'd0)
            return 4'd1;
        else if (req > 4'(MAX_LEN))
            return 4'(MAX_LEN);
        else
            return req;
    endfunction

endpackage

// File: rtl/uart_ftx_baud.sv
module uart_ftx_baud #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic             evt
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   nxt;

    assign nxt = {1'b0, cnt} + 1'b1;
    // a period of 0 fires every tick, like a period of 1
    assign evt = tick && (nxt >= {1'b0, period});

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (tick)
            cnt <= evt ? '0 : nxt[CNT_W-1:0];
    end

    // R1: after a bit event the timer starts a fresh period
    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        evt |=> (cnt == '0));

    // R1: the count never moves without a tick
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart) |=> $stable(cnt));

endmodule

// File: rtl/uart_ftx_shift.sv
module uart_ftx_shift
    import uart_ftx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  sh_ctl_t           ctl,
    input  logic [DATA_W-2:0] load_word,
    input  logic [LEN_W-1:0]  load_len,
    output logic              bit_out,
    output logic [LEN_W-1:0]  bits_left,
    output logic              ones_lsb
);
    logic [DATA_W-2:0] sreg;
    logic [LEN_W-1:0]  ones_cnt;

    assign bit_out  = sreg[0];
    assign ones_lsb = ones_cnt[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg      <= '0;
            bits_left <= '0;
            ones_cnt  <= '0;
        end else if (ctl.load) begin
            sreg      <= load_word;
            bits_left <= load_len;
            ones_cnt  <= '0;
        end else if (ctl.shift) begin
            sreg      <= sreg >> 1;
            bits_left <= bits_left - 1'b1;
            ones_cnt  <= ones_cnt + LEN_W'(sreg[0]);
        end
    end

    // R5: the bit counter stays within the supported word length
    p_len_bound_r5: assert property (@(posedge clk) disable iff (rst)
        bits_left <= LEN_W'(MAX_LEN));

    // R5: a shift is only requested while bits remain
    p_shift_guard_r5: assert property (@(posedge clk) disable iff (rst)
        ctl.shift |-> (bits_left != '0));

    // R6: the ones count restarts with every new word
    p_ones_clear_r6: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> (ones_cnt == '0));

endmodule

// File: rtl/uart_flag_tx.sv
module uart_flag_tx
    import uart_ftx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tmr_tick,
    input  logic              init,
    input  logic [CNT_W-1:0]  baud_period,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [1:0]        par_mode,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] data_reg,
    output logic              txd,
    output logic              irq
);
    localparam int FLAG = DATA_W - 1;

    tx_state_e        state;
    logic             evt;
    logic             take;
    logic             bit_out;
    logic             ones_lsb;
    logic [LEN_W-1:0] bits_left;
    sh_ctl_t          ctl;

    assign take      = (state == TX_IDLE) && evt && !data_reg[FLAG] && !init;
    assign ctl.load  = take;
    assign ctl.shift = (state == TX_DATA) && evt && (bits_left != '0) && !init;

    uart_ftx_baud #(.CNT_W(CNT_W)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .restart (init),
        .tick    (tmr_tick),
        .period  (baud_period),
        .evt     (evt)
    );

    uart_ftx_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .load_word (data_reg[DATA_W-2:0]),
        .load_len  (clamp_len(word_len)),
        .bit_out   (bit_out),
        .bits_left (bits_left),
        .ones_lsb  (ones_lsb)
    );

    // frame sequencer and line driver
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            txd   <= 1'b1;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (init) begin
                state <= TX_IDLE;
                txd   <= 1'b1;
                irq   <= 1'b1;
            end else if (evt) begin
                unique case (state)
                    TX_IDLE: begin
                        if (take) begin
                            txd   <= 1'b0;
                            irq   <= 1'b1;
                            state <= TX_DATA;
                        end
                    end
                    TX_DATA: begin
                        if (bits_left != '0) begin
                            txd <= bit_out;
                        end else if (par_mode[1]) begin
                            txd   <= ones_lsb ^ par_mode[0];
                            state <= TX_PAR;
                        end else begin
                            txd   <= 1'b1;
                            state <= TX_IDLE;
                        end
                    end
                    TX_PAR: begin
                        txd   <= 1'b1;
                        state <= TX_IDLE;
                    end
                    default: state <= TX_IDLE;
                endcase
            end
        end
    end

    // shared register: host write has priority over the flag write-back
    always_ff @(posedge clk) begin
        if (rst)
            data_reg <= DATA_W'(1) << FLAG;
        else if (host_wr)
            data_reg <= host_wdata;
        else if (take)
            data_reg[FLAG] <= 1'b1;
    end

    // R8: the line rests high whenever no frame is in progress
    p_idle_high_r8: assert property (@(posedge clk) disable iff (rst)
        (state == TX_IDLE) |-> txd);

    // R4: a take drives the start bit, raises irq and sets the empty flag
    p_take_r4: assert property (@(posedge clk) disable iff (rst)
        (take && !host_wr) |=> (!txd && irq && data_reg[FLAG]));

    // R9: irq only follows init or the falling start edge
    p_irq_src_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(init) || $fell(txd)));

    // R1: the line only moves on a timer tick or init
    p_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (!tmr_tick && !init) |=> $stable(txd));

    // R2: with the flag set and nothing written, the idle block stays idle
    p_empty_r2: assert property (@(posedge clk) disable iff (rst)
        ((state == TX_IDLE) && data_reg[FLAG] && !host_wr && !init) |=> (state == TX_IDLE));

endmodule

// File: tb/uart_flag_tx_bench.sv
module uart_flag_tx_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tmr_tick = 1'b1;
    logic        init = 1'b0;
    logic [15:0] baud_period = 16'd4;
    logic [3:0]  word_len = 4'd8;
    logic [1:0]  par_mode = 2'b00;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] data_reg;
    logic        txd;
    logic        irq;

    int     checks = 0;
    int     errors = 0;
    int     cpt = 1;
    int     tph = 0;
    longint cyc = 0;
    bit     done = 0;

    always #2.5 clk = ~clk;

    uart_flag_tx u_uart_flag_tx (
        .clk(clk), .rst(rst), .tmr_tick(tmr_tick), .init(init),
        .baud_period(baud_period), .word_len(word_len), .par_mode(par_mode),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .data_reg(data_reg), .txd(txd), .irq(irq)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // tick pattern: one tick every cpt cycles
    always @(negedge clk) begin
        tph      <= tph + 1;
        tmr_tick <= ((tph + 1) % cpt) == 0;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int eff_len(input int l);
        if (l == 0) return 1;
        if (l > 14) return 14;
        return l;
    endfunction

    function automatic bit par_bit(input logic [15:0] d, input int len, input logic [1:0] pm);
        int ones = 0;
        for (int i = 0; i < len; i++) ones += d[i];
        return ones[0] ^ pm[0];
    endfunction

    task automatic write_word(input logic [15:0] w);
        @(negedge clk);
        host_wr    = 1'b1;
        host_wdata = w;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    // Waits for the start edge and checks the whole frame. If nxt_ok, writes
    // nxt right after the start edge so the next frame is already waiting.
    task automatic check_frame(input logic [15:0] d, input int B, input bit nxt_ok,
                               input logic [15:0] nxt, output longint fall);
        int waited = 0;
        int len = eff_len(int'(word_len));
        int nb;
        bit exp_b;
        while (txd !== 1'b0 && waited < B + 3) begin
            @(negedge clk);
            waited++;
        end
        fall = cyc;
        chk(txd === 1'b0, "R3 start within one period", waited, B + 2);
        chk(irq === 1'b1, "R4 irq with start bit", irq, 1);
        chk(data_reg === {1'b1, d[14:0]}, "R4 flag set on take", data_reg, {1'b1, d[14:0]});
        nb = 1 + len + (par_mode[1] ? 1 : 0) + 1;
        if (nxt_ok) begin
            @(negedge clk);
            host_wr = 1'b1; host_wdata = nxt;
            @(negedge clk);
            host_wr = 1'b0;
            repeat (B / 2 - 2) @(negedge clk);
        end else begin
            repeat (B / 2) @(negedge clk);
        end
        for (int k = 0; k < nb; k++) begin
            if (k == 0) exp_b = 1'b0;
            else if (k <= len) exp_b = d[k-1];
            else if (k == nb - 1) exp_b = 1'b1;
            else exp_b = par_bit(d, len, par_mode);
            if (k == 0)
                chk(txd === exp_b, "R4 start bit low", txd, exp_b);
            else if (k <= len)
                chk(txd === exp_b, "R5 data bit LSB first", txd, exp_b);
            else if (k == nb - 1)
                chk(txd === exp_b, "R8 stop bit high", txd, exp_b);
            else
                chk(txd === exp_b, "R6 R7 parity bit", txd, exp_b);
            if (k != nb - 1) repeat (B) @(negedge clk);
        end
        repeat (B - B / 2 - 1) @(negedge clk);
    endtask

    initial begin
        longint f1, f2, fd;
        bit stayed;
        logic [15:0] w;

        repeat (3) @(negedge clk);
        chk(txd === 1'b1, "R10 reset line high", txd, 1);
        chk(irq === 1'b0, "R10 reset irq low", irq, 0);
        chk(data_reg === 16'h8000, "R10 reset register", data_reg, 16'h8000);
        rst = 1'b0;

        // R9: init pulses irq and keeps the line high
        @(negedge clk); init = 1'b1;
        @(negedge clk); init = 1'b0;
        chk(irq === 1'b1 && txd === 1'b1, "R9 init irq and line", {irq, txd}, 3);
        @(negedge clk);
        chk(irq === 1'b0, "R9 irq single cycle", irq, 0);

        // R2: a word with the flag set is not sent
        write_word(16'hC0A5);
        stayed = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (txd !== 1'b1 || irq !== 1'b0) stayed = 0;
        end
        chk(stayed, "R2 flagged word ignored", stayed, 1);
        chk(data_reg === 16'hC0A5, "R2 register holds write", data_reg, 16'hC0A5);

        // directed: 8 bits, no parity (mode 01), period 4
        baud_period = 16'd4; word_len = 4'd8; par_mode = 2'b01;
        write_word(16'h00B6);
        check_frame(16'h00B6, 4, 0, '0, f1);

        // R7 even and odd parity on the same word
        par_mode = 2'b10;
        write_word(16'h0053);
        check_frame(16'h0053, 4, 0, '0, f1);
        par_mode = 2'b11;
        write_word(16'h0053);
        check_frame(16'h0053, 4, 0, '0, f1);

        // R5 clamp: 0 acts as 1, 15 acts as 14
        par_mode = 2'b10; word_len = 4'd0;
        write_word(16'h7FFF);
        check_frame(16'h7FFF, 4, 0, '0, f1);
        word_len = 4'd15;
        write_word(16'h6A5B);
        check_frame(16'h6A5B, 4, 0, '0, f1);

        // R8 back to back: stop lasts exactly one period before the next start
        word_len = 4'd5; par_mode = 2'b11; baud_period = 16'd6;
        write_word(16'h0015);
        check_frame(16'h0015, 6, 1, 16'h000A, f1);
        check_frame(16'h000A, 6, 0, '0, f2);
        fd = f2 - f1;
        chk(fd == 8 * 6, "R8 start spacing back to back", fd, 8 * 6);

        // R1: ticks on alternate cycles double the bit length in cycles
        cpt = 2; word_len = 4'd6; par_mode = 2'b00; baud_period = 16'd3;
        write_word(16'h002D);
        check_frame(16'h002D, 6, 0, '0, f1);
        cpt = 1;

        // R9: init in mid frame drops the frame
        baud_period = 16'd5; word_len = 4'd8;
        write_word(16'h0000);
        while (txd !== 1'b0) @(negedge clk);
        repeat (7) @(negedge clk);
        init = 1'b1;
        @(negedge clk); init = 1'b0;
        chk(txd === 1'b1 && irq === 1'b1, "R9 init aborts frame", {txd, irq}, 3);
        stayed = 1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) stayed = 0;
        end
        chk(stayed, "R9 line stays high after abort", stayed, 1);

        // random frames
        void'($urandom(32'd1234));
        for (int n = 0; n < 40; n++) begin
            baud_period = 16'($urandom_range(1, 7));
            word_len    = 4'($urandom_range(0, 15));
            par_mode    = 2'($urandom_range(0, 3));
            w           = {1'b0, 15'($urandom)};
            write_word(w);
            check_frame(w, int'(baud_period), 0, '0, f1);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule